// File: doc/BRIEF.md
# Enable-Wave Fixed-Latency Execution Pipeline

This block is an execution unit framed by register stages. An issuing agent presents two operands and a flag word together with an issue strobe. On that clock edge the operands and flags are captured into an input register, and a one-bit enable flip-flop records whether anything was issued. The enable then moves down each result lane one stage per cycle, alongside the data it qualifies. Stages that receive an enable of zero keep their registers unchanged, so idle parts of the pipeline do not toggle.

The unit has two result ports, and each has its own fixed latency. Port A returns the sum of the operands plus a carry-in flag after `LAT_A` cycles. Port B returns the XOR of the operands rotated left by one bit after `LAT_B` cycles. The consumer receives no valid or ready signal. It works out when a result lands from the issue cycle and the latency of the port.

A build option (`GATED = 0`) lets every stage clock on every cycle. In that mode an output register carries a result only in its arrival cycle and reads zero in every other cycle.

Top module: `ewp_unit`

## Requirements
- R1: When `issue_i` is 1 at a rising edge, the unit captures `opa_i`, `opb_i` and `flags_i` on that edge, and the enable flip-flop becomes 1. Only `flags_i` bit 0 affects the arithmetic, where it acts as the carry-in of port A.
- R2: When `issue_i` is 0 at a rising edge, the enable flip-flop becomes 0 and the captured operands keep their values. No result is produced on either port for that cycle, however the operand inputs move.
- R3: An issue captured at edge k writes `res_a_o` at edge k+`LAT_A` with `(opa + opb + flags[0]) mod 2^DATA_W`.
- R4: An issue captured at edge k writes `res_b_o` at edge k+`LAT_B` with `opa ^ opb` rotated left by one bit, so that bit `DATA_W-1` of the XOR lands in bit 0.
- R5: With `GATED = 1`, an output register keeps its previous value in every cycle in which no result arrives on it.
- R6: Issues on consecutive cycles each deliver their own result on each port in consecutive cycles, with no bubble inserted.
- R7: A synchronous active-high `rst_i` clears both output registers to zero and clears every enable bit, which discards any result in flight. Data stage registers are not reset.
- R8: With `GATED = 0`, every stage loads on every cycle. An output register holds a result only in its arrival cycle and holds zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Issue strobe for the current cycle |
| opa_i | input | DATA_W | First operand |
| opb_i | input | DATA_W | Second operand |
| flags_i | input | FLAG_W | Flag word; bit 0 is the carry-in of port A |
| res_a_o | output | DATA_W | Port A result register (sum) |
| res_b_o | output | DATA_W | Port B result register (rotated XOR) |

## Verification
The bound checker checks several properties on every cycle. It checks that the enable flip-flop follows the issue strobe and that the captured operands stay put in idle cycles. In gated mode it checks that an output register is stable whenever its lane's enable is low at the final stage, and in free-running mode that the register is zero in that case. It also checks that reset clears the outputs. Only the bench's scenarios can show that the value written is the correct function of the operands. They also show that it lands exactly `LAT_A` or `LAT_B` edges after issue, that back-to-back issues stay separate, and that reset discards results in flight.

// File: rtl/ewp_pkg.sv
package ewp_pkg;

   // Function computed at the head of a result lane
   typedef enum logic [0:0] {
      FN_ADD = 1'b0,   // a + b + carry-in
      FN_XRL = 1'b1    // (a ^ b) rotated left by one
   } fn_e;

endpackage

// File: rtl/ewp_issue_reg.sv
module ewp_issue_reg #(
   parameter int DATA_W = 32,
   parameter int FLAG_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              issue_i,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic              en_o,
   output logic [DATA_W-1:0] opa_o,
   output logic [DATA_W-1:0] opb_o,
   output logic [FLAG_W-1:0] flags_o
);

   // Enable flip-flop: records whether this cycle issued
   always_ff @(posedge clk_i) begin
      if (rst_i) en_o <= 1'b0;
      else       en_o <= issue_i;
   end

   // Operand/flag register: loads only on issue, otherwise holds
   always_ff @(posedge clk_i) begin
      if (issue_i) begin
         opa_o   <= opa_i;
         opb_o   <= opb_i;
         flags_o <= flags_i;
      end
   end

endmodule

// File: rtl/ewp_fn.sv
module ewp_fn #(
   parameter int          DATA_W = 32,
   parameter ewp_pkg::fn_e FN    = ewp_pkg::FN_ADD
) (
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] res_o
);

   if (FN == ewp_pkg::FN_ADD) begin : g_add
      assign res_o = opa_i + opb_i + DATA_W'(cin_i);
   end else begin : g_xrl
      logic [DATA_W-1:0] mix;
      logic              unused_cin;
      assign mix        = opa_i ^ opb_i;
      assign res_o      = {mix[DATA_W-2:0], mix[DATA_W-1]};
      assign unused_cin = cin_i;
   end

endmodule

// File: rtl/ewp_stage.sv
module ewp_stage #(
   parameter int DATA_W = 32,
   parameter bit GATED  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic [DATA_W-1:0] d_i,
   output logic              en_o,
   output logic [DATA_W-1:0] d_o
);

   // The enable bit always advances
   always_ff @(posedge clk_i) begin
      if (rst_i) en_o <= 1'b0;
      else       en_o <= en_i;
   end

   if (GATED) begin : g_gated
      // Data only moves with a live enable
      always_ff @(posedge clk_i) begin
         if (en_i) d_o <= d_i;
      end
   end else begin : g_free
      always_ff @(posedge clk_i) begin
         d_o <= d_i;
      end
   end

endmodule

// File: rtl/ewp_out_reg.sv
module ewp_out_reg #(
   parameter int DATA_W = 32,
   parameter bit GATED  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);

   if (GATED) begin : g_gated
      // Hold the last valid result until the next arrival
      always_ff @(posedge clk_i) begin
         if (rst_i)     q_o <= '0;
         else if (en_i) q_o <= d_i;
      end
   end else begin : g_free
      // Loads every cycle; a result is visible for one cycle only
      always_ff @(posedge clk_i) begin
         if (rst_i) q_o <= '0;
         else       q_o <= en_i ? d_i : '0;
      end
   end

endmodule

// File: rtl/ewp_port_lane.sv
module ewp_port_lane #(
   parameter int           DATA_W = 32,
   parameter int           LAT    = 1,
   parameter bit           GATED  = 1'b1,
   parameter ewp_pkg::fn_e FN     = ewp_pkg::FN_ADD
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic              cin_i,
   output logic              arrive_o,
   output logic [DATA_W-1:0] res_o
);

   localparam int NSTG = LAT;   // slots: head plus LAT-1 middle stages

   logic [DATA_W-1:0] pd [NSTG];
   logic              pv [NSTG];

   ewp_fn #(.DATA_W(DATA_W), .FN(FN)) u_fn (
      .opa_i (opa_i),
      .opb_i (opb_i),
      .cin_i (cin_i),
      .res_o (pd[0])
   );
   assign pv[0] = en_i;

   for (genvar j = 1; j < NSTG; j++) begin : g_stage
      ewp_stage #(.DATA_W(DATA_W), .GATED(GATED)) u_stage (
         .clk_i (clk_i),
         .rst_i (rst_i),
         .en_i  (pv[j-1]),
         .d_i   (pd[j-1]),
         .en_o  (pv[j]),
         .d_o   (pd[j])
      );
   end

   ewp_out_reg #(.DATA_W(DATA_W), .GATED(GATED)) u_out (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .en_i  (pv[NSTG-1]),
      .d_i   (pd[NSTG-1]),
      .q_o   (res_o)
   );

   assign arrive_o = pv[NSTG-1];

endmodule

// File: rtl/ewp_unit.sv
module ewp_unit #(
   parameter int DATA_W = 32,
   parameter int FLAG_W = 4,
   parameter int LAT_A  = 1,
   parameter int LAT_B  = 3,
   parameter bit GATED  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              issue_i,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [DATA_W-1:0] res_a_o,
   output logic [DATA_W-1:0] res_b_o
);

   localparam int CIN_BIT = 0;

   // Elaboration-time parameter checks
   if (DATA_W < 2) begin : g_bad_width
      initial $fatal(1, "ewp_unit: DATA_W must be at least 2");
   end
   if (FLAG_W < 1) begin : g_bad_flags
      initial $fatal(1, "ewp_unit: FLAG_W must be at least 1");
   end
   if (LAT_A < 1 || LAT_B < 1) begin : g_bad_lat
      initial $fatal(1, "ewp_unit: port latencies must be at least 1");
   end

   logic              en_q;
   logic [DATA_W-1:0] opa_q;
   logic [DATA_W-1:0] opb_q;
   logic [FLAG_W-1:0] flags_q;
   logic              arr_a;
   logic              arr_b;
   logic              unused_flags;

   ewp_issue_reg #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_issue (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .issue_i (issue_i),
      .opa_i   (opa_i),
      .opb_i   (opb_i),
      .flags_i (flags_i),
      .en_o    (en_q),
      .opa_o   (opa_q),
      .opb_o   (opb_q),
      .flags_o (flags_q)
   );

   assign unused_flags = ^flags_q;

   ewp_port_lane #(
      .DATA_W (DATA_W), .LAT (LAT_A), .GATED (GATED), .FN (ewp_pkg::FN_ADD)
   ) u_lane_a (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .en_i     (en_q),
      .opa_i    (opa_q),
      .opb_i    (opb_q),
      .cin_i    (flags_q[CIN_BIT]),
      .arrive_o (arr_a),
      .res_o    (res_a_o)
   );

   ewp_port_lane #(
      .DATA_W (DATA_W), .LAT (LAT_B), .GATED (GATED), .FN (ewp_pkg::FN_XRL)
   ) u_lane_b (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .en_i     (en_q),
      .opa_i    (opa_q),
      .opb_i    (opb_q),
      .cin_i    (flags_q[CIN_BIT]),
      .arrive_o (arr_b),
      .res_o    (res_b_o)
   );

endmodule

// File: rtl/ewp_unit_chk.sv
module ewp_unit_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              gated_i,
   input logic              issue_i,
   input logic              en_q,
   input logic [DATA_W-1:0] opa_q,
   input logic [DATA_W-1:0] opb_q,
   input logic              arr_a,
   input logic              arr_b,
   input logic [DATA_W-1:0] res_a,
   input logic [DATA_W-1:0] res_b
);

   AST_EN_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
      issue_i |=> en_q);                                          // R1
   AST_EN_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      !issue_i |=> !en_q);                                        // R2
   AST_OPS_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !issue_i |=> ($stable(opa_q) && $stable(opb_q)));           // R2
   AST_A_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
      (gated_i && !arr_a) |=> $stable(res_a));                    // R5
   AST_B_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
      (gated_i && !arr_b) |=> $stable(res_b));                    // R5
   AST_FREE_A_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      (!gated_i && !arr_a) |=> (res_a == '0));                    // R8
   AST_FREE_B_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      (!gated_i && !arr_b) |=> (res_b == '0));                    // R8
   AST_RST_CLEAR: assert property (@(posedge clk_i)
      rst_i |=> ((res_a == '0) && (res_b == '0) && !en_q));       // R7

endmodule

bind ewp_unit ewp_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .gated_i (GATED),
   .issue_i (issue_i),
   .en_q    (en_q),
   .opa_q   (opa_q),
   .opb_q   (opb_q),
   .arr_a   (arr_a),
   .arr_b   (arr_b),
   .res_a   (res_a_o),
   .res_b   (res_b_o)
);

// File: tb/ewp_unit_test.sv
`timescale 1ns/1ps
module ewp_unit_test;

   localparam int W  = 32;
   localparam int FW = 4;
   localparam int LA = 1;
   localparam int LB = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          issue = 1'b0;
   logic [W-1:0]  opa = '0;
   logic [W-1:0]  opb = '0;
   logic [FW-1:0] flg = '0;
   logic [W-1:0]  ra_g, rb_g, ra_f, rb_f;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    finished = 1'b0;
   string phase    = "";

   // Expected-result queues, one slot per cycle of latency
   logic         qa_v [LA];
   logic [W-1:0] qa_d [LA];
   logic         qb_v [LB];
   logic [W-1:0] qb_d [LB];
   logic [W-1:0] ea_g, eb_g, ea_f, eb_f;
   logic         hit_a, hit_b;

   always #2.5 clk = ~clk;   // 200 MHz

   ewp_unit #(.DATA_W(W), .FLAG_W(FW), .LAT_A(LA), .LAT_B(LB), .GATED(1'b1)) uut (
      .clk_i (clk), .rst_i (rst), .issue_i (issue), .opa_i (opa), .opb_i (opb),
      .flags_i (flg), .res_a_o (ra_g), .res_b_o (rb_g));

   ewp_unit #(.DATA_W(W), .FLAG_W(FW), .LAT_A(LA), .LAT_B(LB), .GATED(1'b0)) uut_free (
      .clk_i (clk), .rst_i (rst), .issue_i (issue), .opa_i (opa), .opb_i (opb),
      .flags_i (flg), .res_a_o (ra_f), .res_b_o (rb_f));

   function automatic logic [W-1:0] f_sum(input logic [W-1:0] a, b, input logic [FW-1:0] f);
      return a + b + W'(f[0]);
   endfunction

   function automatic logic [W-1:0] f_rx(input logic [W-1:0] a, b);
      logic [W-1:0] x;
      x = a ^ b;
      return (x << 1) | (x >> (W-1));
   endfunction

   task automatic check(input string tag, input string what, input logic [W-1:0] act, exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic clear_model();
      for (int i = 0; i < LA; i++) begin qa_v[i] = 1'b0; qa_d[i] = '0; end
      for (int i = 0; i < LB; i++) begin qb_v[i] = 1'b0; qb_d[i] = '0; end
      ea_g = '0; eb_g = '0; ea_f = '0; eb_f = '0;
      hit_a = 1'b0; hit_b = 1'b0;
   endtask

   // Called right after a rising edge with the values presented at that edge
   task automatic model_edge(input logic iss, input logic [W-1:0] a, b, input logic [FW-1:0] f);
      hit_a = qa_v[LA-1];
      hit_b = qb_v[LB-1];
      if (hit_a) ea_g = qa_d[LA-1];
      if (hit_b) eb_g = qb_d[LB-1];
      ea_f = hit_a ? qa_d[LA-1] : '0;
      eb_f = hit_b ? qb_d[LB-1] : '0;
      for (int i = LA-1; i > 0; i--) begin qa_v[i] = qa_v[i-1]; qa_d[i] = qa_d[i-1]; end
      for (int i = LB-1; i > 0; i--) begin qb_v[i] = qb_v[i-1]; qb_d[i] = qb_d[i-1]; end
      qa_v[0] = iss; qa_d[0] = f_sum(a, b, f);
      qb_v[0] = iss; qb_d[0] = f_rx(a, b);
   endtask

   task automatic compare();
      string ta, tb, tfa, tfb;
      ta  = (phase != "") ? phase : (hit_a ? "R3" : "R5");
      tb  = (phase != "") ? phase : (hit_b ? "R4" : "R5");
      tfa = (phase != "") ? phase : (hit_a ? "R3" : "R8");
      tfb = (phase != "") ? phase : (hit_b ? "R4" : "R8");
      check(ta,  "gated port A", ra_g, ea_g);
      check(tb,  "gated port B", rb_g, eb_g);
      check(tfa, "free port A",  ra_f, ea_f);
      check(tfb, "free port B",  rb_f, eb_f);
   endtask

   // One cycle: drive at the falling edge, model at the rising edge, check at the next fall
   task automatic step(input logic iss, input logic [W-1:0] a, b, input logic [FW-1:0] f);
      issue = iss; opa = a; opb = b; flg = f;
      @(posedge clk);
      model_edge(iss, a, b, f);
      @(negedge clk);
      compare();
   endtask

   task automatic do_reset();
      rst = 1'b1; issue = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      clear_model();
      check("R7", "reset port A gated", ra_g, '0);
      check("R7", "reset port B gated", rb_g, '0);
      check("R7", "reset port A free",  ra_f, '0);
      check("R7", "reset port B free",  rb_f, '0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      clear_model();
      @(negedge clk);
      do_reset();

      // R1: carry-in flag from bit 0, upper flag bits ignored
      phase = "R1";
      step(1'b1, 32'h0000_0010, 32'h0000_0020, 4'b0001);
      step(1'b1, 32'h0000_0010, 32'h0000_0020, 4'b1110);
      repeat (LB) step(1'b0, '0, '0, '0);

      // R3/R4 corner values: wrap-around and MSB rotated into bit 0
      phase = "R3";
      step(1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 4'b0001);
      step(1'b1, 32'h8000_0000, 32'h0000_0000, 4'b0000);
      repeat (LB) step(1'b0, '0, '0, '0);

      // R2: idle cycles with moving operand inputs must not create results
      phase = "R2";
      for (int i = 0; i < LB + 3; i++) step(1'b0, $urandom, $urandom, 4'($urandom));

      // R6: back-to-back issues
      phase = "R6";
      for (int i = 0; i < 8; i++) step(1'b1, 32'h1111_1111 * (i + 1), 32'h0F0F_0F0F ^ i, 4'(i));
      repeat (LB) step(1'b0, '0, '0, '0);

      // R7: reset with results in flight discards them
      phase = "R7";
      step(1'b1, 32'hDEAD_BEEF, 32'h1234_5678, 4'b0001);
      step(1'b1, 32'hCAFE_0000, 32'h0000_F00D, 4'b0000);
      do_reset();
      repeat (LB + 2) step(1'b0, $urandom, $urandom, 4'($urandom));

      // Random traffic with random gaps
      phase = "";
      for (int i = 0; i < 1500; i++) begin
         logic go;
         go = ($urandom % 100) < 55;
         step(go, $urandom, $urandom, 4'($urandom));
      end
      repeat (LB + 1) step(1'b0, '0, '0, '0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule